// File: doc/BRIEF.md
# Permuted 3D Element Index Generator

This block converts a stream of linear element steps into remapped element indices. It treats a register's elements as a three-dimensional array and walks that array with three nested counters. A 32-bit shape word sets the size of each dimension and the nesting order of the counters. The order is one of six permutations and can be changed at run time. A matrix held in consecutive registers can therefore be read in transposed order without moving any data.

Every step strobe emits one index, computed as `x + y*X + z*X*Y`, where X, Y and Z are the dimension sizes. When the walk passes the last element of the array, the counters return to zero. A vector longer than the array therefore revisits the same elements. An all-zero shape word turns remapping off, and the block then emits the plain step count. A start input restarts the walk from the first element.

Top module: `remap_idx_gen`

## Requirements
- R1: After a synchronous active-high reset, `idx_valid_o` is low and the first step emits index 0.
- R2: Shape word fields: X size field in bits 6..0, Y size field in bits 14..8, Z size field in bits 22..16, order code in bits 26..24.
- R3: Each size field holds the element count minus one: a field of 0 means 1 element and a field of 6 means 7 elements.
- R4: When bits 6..0, 14..8, 22..16 and 26..24 are all zero, the index equals the number of steps since the last reset or start, counting from 0 and wrapping modulo 2^21.
- R5: The order codes list the counters from innermost to outermost: 0 = x,y,z; 1 = x,z,y; 2 = y,x,z; 3 = y,z,x; 4 = z,x,y; 5 = z,y,x.
- R6: Each step increments the innermost counter. A counter that reaches its count minus one returns to 0 instead, and the next counter in the order increments.
- R7: The emitted index is x + y*(xfield+1) + z*(xfield+1)*(yfield+1). Order code 0, or any order code when two or more dimensions hold one element, gives the plain linear order.
- R8: After (xfield+1)*(yfield+1)*(zfield+1) steps, all counters return to 0 and the index sequence repeats.
- R9: Order codes 6 and 7 behave exactly like order code 0.
- R10: A step sampled on a rising edge drives `idx_valid_o` high with its index during the following cycle. A cycle with no step leaves `idx_valid_o` low.
- R11: `start_i` resets the walk. If `start_i` and `step_i` are high in the same cycle, that step emits the first element (index 0), and the next step emits the second element of the walk.
- R12: Bits 7, 15, 23 and 31..27 of the shape word have no effect on the emitted indices or on the decision to bypass remapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shape_i | input | 32 | Shape word: dimension sizes and order code |
| start_i | input | 1 | Restart the walk at the first element |
| step_i | input | 1 | Advance one element and emit its index |
| idx_valid_o | output | 1 | Index on `idx_o` is valid this cycle |
| idx_o | output | 21 | Remapped element index |

## Verification
The restart and the step can fall in the same cycle. This is the case most likely to go wrong, because the step must use the cleared counters and not the old ones. The bench provokes it at the start of every configuration in the sweep, and again part-way through a walk on a larger shape. It expects index 0 on the first step, and on the following step it expects the second element of the selected order, computed from its own model of the counters.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int DIM_W = 7;
    localparam int NAX   = 3;
    localparam int IDX_W = NAX * DIM_W;
    localparam int SZ_W  = DIM_W + 1;
    localparam int AREA_W = 2 * SZ_W;

    typedef logic [DIM_W-1:0]            dim_t;
    typedef logic [IDX_W-1:0]            idx_t;
    typedef logic [1:0]                  axis_t;
    typedef logic [NAX-1:0][DIM_W-1:0]   dimv_t;
    typedef logic [NAX-1:0][1:0]         ord_t;

    typedef enum logic [2:0] {
        ORD_XYZ = 3'd0,
        ORD_XZY = 3'd1,
        ORD_YXZ = 3'd2,
        ORD_YZX = 3'd3,
        ORD_ZXY = 3'd4,
        ORD_ZYX = 3'd5
    } perm_e;

    typedef struct packed {
        dimv_t  lim;     // per-axis count minus one, index 0=x 1=y 2=z
        perm_e  perm;
        logic   bypass;
    } shape_t;

    // Pull the meaningful fields out of the shape word; reserved bits are dropped.
    function automatic shape_t unpack_shape(logic [31:0] w);
        shape_t s;
        logic [2:0] code;
        s.lim[0] = w[6:0];
        s.lim[1] = w[14:8];
        s.lim[2] = w[22:16];
        code     = w[26:24];
        s.perm   = (code > 3'd5) ? ORD_XYZ : perm_e'(code);
        s.bypass = (w[6:0] == '0) && (w[14:8] == '0) && (w[22:16] == '0) && (code == 3'd0);
        return s;
    endfunction

    // Axis visited at each nesting position, innermost at position 0.
    function automatic ord_t perm_order(perm_e p);
        ord_t o;
        case (p)
            ORD_XZY: o = {2'd1, 2'd2, 2'd0};
            ORD_YXZ: o = {2'd2, 2'd0, 2'd1};
            ORD_YZX: o = {2'd0, 2'd2, 2'd1};
            ORD_ZXY: o = {2'd1, 2'd0, 2'd2};
            ORD_ZYX: o = {2'd0, 2'd1, 2'd2};
            default: o = {2'd2, 2'd1, 2'd0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/remap_cfg_decode.sv
module remap_cfg_decode
    import remap_pkg::*;
(
    input  logic [31:0]       shape_i,
    output dimv_t             lim_o,
    output ord_t              ord_o,
    output logic              bypass_o,
    output logic [SZ_W-1:0]   xsize_o,
    output logic [AREA_W-1:0] xysize_o
);
    shape_t           sh;
    logic [SZ_W-1:0]  ysize;

    always_comb begin
        sh       = unpack_shape(shape_i);
        lim_o    = sh.lim;
        ord_o    = perm_order(sh.perm);
        bypass_o = sh.bypass;
        xsize_o  = {1'b0, sh.lim[0]} + SZ_W'(1);
        ysize    = {1'b0, sh.lim[1]} + SZ_W'(1);
        xysize_o = AREA_W'(xsize_o) * AREA_W'(ysize);
    end

endmodule

// File: rtl/remap_walker.sv
module remap_walker
    import remap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  step_i,
    input  dimv_t lim_i,
    input  ord_t  ord_i,
    output dimv_t cur_o,
    output idx_t  lin_o
);
    dimv_t            cnt_q;
    idx_t             lin_q;
    dimv_t            nxt;
    logic [NAX-1:0]   at_top;
    logic [NAX-1:0]   bump;

    // A start in the same cycle makes this step use the cleared counters.
    always_comb begin
        cur_o = start_i ? '0 : cnt_q;
        lin_o = start_i ? '0 : lin_q;
    end

    // Carry ripples from the innermost position outward in the selected order.
    always_comb begin
        logic carry;
        carry = 1'b1;
        bump  = '0;
        for (int p = 0; p < NAX; p++) begin
            bump[ord_i[p]] = carry;
            carry          = carry & at_top[ord_i[p]];
        end
    end

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        assign at_top[a] = (cur_o[a] >= lim_i[a]);
        assign nxt[a]    = !bump[a] ? cur_o[a]
                         : (at_top[a] ? '0 : cur_o[a] + DIM_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lin_q <= '0;
        end else if (step_i) begin
            cnt_q <= nxt;
            lin_q <= lin_o + IDX_W'(1);
        end else if (start_i) begin
            cnt_q <= '0;
            lin_q <= '0;
        end
    end

    AST_INNER_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_i && !start_i && (cnt_q[ord_i[0]] < lim_i[ord_i[0]]))
        |=> (cnt_q[$past(ord_i[0])] == $past(cnt_q[ord_i[0]]) + DIM_W'(1))); // R6

    AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step_i && !start_i && (cnt_q[ord_i[0]] < lim_i[ord_i[0]]))
        |=> ((cnt_q[$past(ord_i[1])] == $past(cnt_q[ord_i[1]])) &&
             (cnt_q[$past(ord_i[2])] == $past(cnt_q[ord_i[2]])))); // R6

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (start_i && !step_i) |=> ((cnt_q == '0) && (lin_q == '0))); // R11

    AST_LIN_COUNT: assert property (@(posedge clk) disable iff (rst)
        (step_i && !start_i) |=> (lin_q == $past(lin_q) + IDX_W'(1))); // R4

endmodule

// File: rtl/remap_index_calc.sv
module remap_index_calc
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              bypass_i,
    input  dimv_t             cur_i,
    input  idx_t              lin_i,
    input  logic [SZ_W-1:0]   xsize_i,
    input  logic [AREA_W-1:0] xysize_i,
    output logic              valid_o,
    output idx_t              idx_o
);
    idx_t tx_q, ty_q, tz_q;
    logic v_q;

    // Products are registered; only the final add sits after the flops.
    always_ff @(posedge clk) begin
        if (rst) begin
            v_q  <= 1'b0;
            tx_q <= '0;
            ty_q <= '0;
            tz_q <= '0;
        end else begin
            v_q <= step_i;
            if (step_i) begin
                if (bypass_i) begin
                    tx_q <= lin_i;
                    ty_q <= '0;
                    tz_q <= '0;
                end else begin
                    tx_q <= IDX_W'(cur_i[0]);
                    ty_q <= IDX_W'(cur_i[1]) * IDX_W'(xsize_i);
                    tz_q <= IDX_W'(cur_i[2]) * IDX_W'(xysize_i);
                end
            end
        end
    end

    assign valid_o = v_q;
    assign idx_o   = tx_q + ty_q + tz_q;

    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        step_i |=> valid_o); // R10

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> !valid_o); // R10

endmodule

// File: rtl/remap_idx_gen.sv
module remap_idx_gen
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       shape_i,
    input  logic              start_i,
    input  logic              step_i,
    output logic              idx_valid_o,
    output logic [IDX_W-1:0]  idx_o
);
    dimv_t             lim;
    ord_t              ord;
    logic              bypass;
    logic [SZ_W-1:0]   xsize;
    logic [AREA_W-1:0] xysize;
    dimv_t             cur;
    idx_t              lin;

    remap_cfg_decode u_dec (
        .shape_i  (shape_i),
        .lim_o    (lim),
        .ord_o    (ord),
        .bypass_o (bypass),
        .xsize_o  (xsize),
        .xysize_o (xysize)
    );

    remap_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .step_i  (step_i),
        .lim_i   (lim),
        .ord_i   (ord),
        .cur_o   (cur),
        .lin_o   (lin)
    );

    remap_index_calc u_calc (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step_i),
        .bypass_i (bypass),
        .cur_i    (cur),
        .lin_i    (lin),
        .xsize_i  (xsize),
        .xysize_i (xysize),
        .valid_o  (idx_valid_o),
        .idx_o    (idx_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !idx_valid_o); // R1

endmodule

// File: tb/remap_idx_gen_tb.sv
module remap_idx_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] shape;
    logic        start;
    logic        step;
    logic        valid;
    logic [20:0] idx;

    always #4 clk = ~clk;   // 125 MHz

    remap_idx_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .shape_i     (shape),
        .start_i     (start),
        .step_i      (step),
        .idx_valid_o (valid),
        .idx_o       (idx)
    );

    int nvec = 0;
    int nbad = 0;
    int mc[3];
    int mlim[3];
    int mord[3];
    int mlin;
    bit mbyp;

    task automatic chk(bit ok, string req, int act, int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_shape(int x, int y, int z, int p, bit noise);
        shape = {5'b0, 3'(p), 1'b0, 7'(z), 1'b0, 7'(y), 1'b0, 7'(x)};
        if (noise) shape = shape | 32'hF880_8080;   // reserved bits, R12
        mlim[0] = x + 1; mlim[1] = y + 1; mlim[2] = z + 1;
        case (p)
            1: mord = '{0, 2, 1};
            2: mord = '{1, 0, 2};
            3: mord = '{1, 2, 0};
            4: mord = '{2, 0, 1};
            5: mord = '{2, 1, 0};
            default: mord = '{0, 1, 2};   // 0, and illegal 6/7 (R9)
        endcase
        mbyp = (x == 0) && (y == 0) && (z == 0) && (p == 0);
    endtask

    // Called at a negedge: drive, wait one full cycle, check the result.
    task automatic cyc(bit s, bit st, string req);
        int exp;
        int carry;
        exp = 0;
        start = s;
        step  = st;
        if (s) begin
            mc = '{0, 0, 0};
            mlin = 0;
        end
        if (st) begin
            exp = mbyp ? mlin : mc[0] + mc[1] * mlim[0] + mc[2] * mlim[0] * mlim[1];
            mlin++;
            carry = 1;
            for (int p = 0; p < 3; p++) begin
                if (carry == 1) begin
                    if (mc[mord[p]] == mlim[mord[p]] - 1) mc[mord[p]] = 0;
                    else begin
                        mc[mord[p]]++;
                        carry = 0;
                    end
                end
            end
        end
        @(negedge clk);
        chk(valid == st, "R10", int'(valid), int'(st));
        if (st) chk(int'(idx) == exp, req, int'(idx), exp);
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int total;
        string tag;
        rst = 1'b1; start = 1'b0; step = 1'b0;
        set_shape(2, 1, 1, 3, 1'b0);
        mc = '{0, 0, 0}; mlin = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(valid == 1'b0, "R1", int'(valid), 0);
        cyc(1'b0, 1'b1, "R1");          // first step after reset -> 0
        cyc(1'b0, 1'b1, "R5");
        cyc(1'b0, 1'b0, "R10");         // idle cycle

        // Bypass: all-zero shape gives the linear count
        set_shape(0, 0, 0, 0, 1'b0);
        cyc(1'b1, 1'b0, "R4");
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, "R4");
        set_shape(0, 0, 0, 0, 1'b1);    // reserved bits must not break bypass
        cyc(1'b1, 1'b1, "R12");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, "R12");

        // Sweep of small shapes over every order code
        for (int x = 0; x < 3; x++)
            for (int y = 0; y < 3; y++)
                for (int z = 0; z < 3; z++)
                    for (int p = 0; p < 8; p++) begin
                        bit nz;
                        nz = ((x + y + z + p) % 3) == 0;
                        set_shape(x, y, z, p, nz);
                        total = (x + 1) * (y + 1) * (z + 1);
                        cyc(1'b1, 1'b1, "R11");      // start+step together
                        for (int n = 1; n < total + 3; n++) begin
                            if (n >= total)   tag = "R8";
                            else if (p > 5)   tag = "R9";
                            else if (nz)      tag = "R12";
                            else if (p == 0)  tag = "R7";
                            else              tag = "R5";
                            cyc(1'b0, 1'b1, tag);
                        end
                    end

        // Larger shape: field layout and minus-one sizes, carries across axes
        set_shape(6, 4, 3, 3, 1'b0);
        cyc(1'b1, 1'b0, "R11");
        for (int n = 0; n < 8; n++) cyc(1'b0, 1'b1, "R2");
        for (int n = 0; n < 60; n++) cyc(1'b0, 1'b1, "R6");
        cyc(1'b1, 1'b1, "R11");         // restart mid-walk, same cycle as a step
        cyc(1'b0, 1'b1, "R11");
        for (int n = 0; n < 138; n++) cyc(1'b0, 1'b1, "R3");
        for (int n = 0; n < 5; n++) cyc(1'b0, 1'b1, "R8");
        cyc(1'b0, 1'b0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule